// File: doc/BRIEF.md
# Privilege-Gated Performance Counter Bank

This block holds a bank of event counters, each 40 bits wide, with a small control register per counter. Software can preset a counter, read it back and change its control settings through a single request port. While a counter is enabled, every qualified event pulse on its input adds one to the count. When the count wraps past all-ones, a sticky overflow flag is set. If the counter's interrupt enable is on, that flag drives an interrupt request line for the counter.

A counter can be preset to the two's-complement negative of N. It then overflows on exactly the Nth event, which is how software asks for an interrupt after a chosen number of events.

Access is checked against the privilege level carried with each request. Writes are accepted only at level 0. Reads are accepted at level 0, and at any level when the user-read enable input is high. A refused request has no effect on any counter and pulses a fault output. A read can return the full counter or only its low 32 bits. Read data appears in a 64-bit view whose upper reserved bits are always zero.

Top module: `perf_counter_bank`

## Requirements
- R1: Every read returns a 64-bit value whose bits 63:40 are zero. A full-width counter read returns all 40 counter bits.
- R2: A counter read with `req_full_i` low returns only counter bits 31:0, with bits 63:32 zero. With `req_full_i` high it returns bits 39:0.
- R3: A read is granted when `req_priv_i` is 0 or `user_rd_en_i` is high. A refused read still gives `rd_valid_o` and returns zero, and `fault_o` is high for the one cycle that carries that result.
- R4: A write (counter or control) with `req_priv_i` not 0 leaves every counter and control bit unchanged, and raises `fault_o` for one cycle.
- R5: A privileged counter write (`req_ctl_i` low) loads all 40 bits of `req_wdata_i`. If an event reaches the same counter in the same cycle, the written value is kept and the event is dropped.
- R6: Control register layout: bit 0 is enable, bit 1 is interrupt enable, bit 2 is the overflow flag. A control write sets bits 0 and 1 from the data. Writing 1 to bit 2 clears the overflow flag. An enabled counter adds one per event; a disabled counter ignores events.
- R7: An enabled counter at all-ones that sees an event wraps to zero and sets its overflow flag, which then stays set. A counter preset to -N reaches all-ones after N-1 events and overflows on the Nth.
- R8: `irq_o[i]` is high exactly while counter i has both its overflow flag and its interrupt enable set.
- R9: Read data and `rd_valid_o` appear one cycle after the request. A read of an index at or above the counter count returns zero without a fault. A write to such an index is ignored without a fault.
- R10: After reset all counters and control bits are zero and `rd_valid_o`, `fault_o` and `irq_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 18 | One qualified event pulse per counter |
| user_rd_en_i | input | 1 | Lets non-zero privilege levels read |
| req_valid_i | input | 1 | Access request present this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_ctl_i | input | 1 | 1 = control register, 0 = counter |
| req_full_i | input | 1 | Read width: 1 = 40 bits, 0 = low 32 bits |
| req_priv_i | input | 2 | Privilege level of the requester, 0 most privileged |
| req_idx_i | input | 5 | Counter index |
| req_wdata_i | input | 40 | Write data |
| rd_valid_o | output | 1 | Read result valid |
| rd_data_o | output | 64 | Read result |
| fault_o | output | 1 | One-cycle pulse on a refused access |
| irq_o | output | 18 | Per-counter overflow interrupt request |

## Verification
Several rules are checked by assertions on every cycle. The reserved upper read bits stay zero, and narrow reads never carry bits above 31. Refused reads fault and return zero, unprivileged writes fault and leave every counter untouched, and a wrap with interrupt enable set raises an interrupt in the next cycle. The bench scenarios cover what needs a known history: the exact count reached after a preset and N-1 events, the overflow landing on the Nth event for every counter, a write winning over a same-cycle event, and the sticky flag reacting to interrupt-enable changes and to write-one-to-clear.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

  localparam int REG_W   = 64;
  localparam int CTL_EN  = 0;
  localparam int CTL_IEN = 1;
  localparam int CTL_OVF = 2;

  // ones in the low w bits of the register view
  function automatic logic [REG_W-1:0] width_mask(input int w);
    if (w >= REG_W) return '1;
    return (REG_W'(1) << w) - REG_W'(1);
  endfunction

  // trims a zero-extended counter value to the requested read width
  function automatic logic [REG_W-1:0] shape_read(input logic [REG_W-1:0] raw,
                                                  input logic full,
                                                  input int ctr_w,
                                                  input int low_w);
    return raw & width_mask(full ? ctr_w : low_w);
  endfunction

  // builds the control register view
  function automatic logic [REG_W-1:0] ctl_view(input logic en,
                                                input logic ien,
                                                input logic ovf);
    logic [REG_W-1:0] v;
    v = '0;
    v[CTL_EN]  = en;
    v[CTL_IEN] = ien;
    v[CTL_OVF] = ovf;
    return v;
  endfunction

endpackage

// File: rtl/pcb_slice.sv
module pcb_slice import pcb_pkg::*; #(
  parameter int CTR_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic             ld_cnt_i,
  input  logic             ld_ctl_i,
  input  logic [CTR_W-1:0] wdata_i,
  output logic [CTR_W-1:0] cnt_o,
  output logic             en_o,
  output logic             ien_o,
  output logic             ovf_o,
  output logic             irq_o,
  output logic             wrap_o
);

  function automatic logic [CTR_W-1:0] bump(input logic [CTR_W-1:0] c);
    return c + CTR_W'(1);
  endfunction

  logic step;

  // a counter load takes the cycle; a colliding event is lost
  assign step   = en_o && evt_i && !ld_cnt_i;
  assign wrap_o = step && (&cnt_o);
  assign irq_o  = ovf_o && ien_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
      en_o  <= 1'b0;
      ien_o <= 1'b0;
      ovf_o <= 1'b0;
    end else begin
      if (ld_cnt_i)
        cnt_o <= wdata_i;
      else if (step)
        cnt_o <= bump(cnt_o);

      if (ld_ctl_i) begin
        en_o  <= wdata_i[CTL_EN];
        ien_o <= wdata_i[CTL_IEN];
      end

      if (wrap_o)
        ovf_o <= 1'b1;
      else if (ld_ctl_i && wdata_i[CTL_OVF])
        ovf_o <= 1'b0;
    end
  end

endmodule

// File: rtl/pcb_access.sv
module pcb_access #(
  parameter int NUM_CTRS = 18,
  parameter int PRIV_W   = 2,
  parameter int IDX_W    = 5
) (
  input  logic                req_valid_i,
  input  logic                req_write_i,
  input  logic                req_ctl_i,
  input  logic [PRIV_W-1:0]   req_priv_i,
  input  logic [IDX_W-1:0]    req_idx_i,
  input  logic                user_rd_en_i,
  output logic [NUM_CTRS-1:0] wr_ctr_o,
  output logic [NUM_CTRS-1:0] wr_ctl_o,
  output logic                rd_grant_o,
  output logic                idx_hit_o,
  output logic                fault_now_o
);

  logic top_priv;
  logic rd_req;
  logic wr_ok;

  assign top_priv    = (req_priv_i == '0);
  assign rd_req      = req_valid_i && !req_write_i;
  assign wr_ok       = req_valid_i && req_write_i && top_priv;
  assign idx_hit_o   = ({1'b0, req_idx_i} < (IDX_W+1)'(NUM_CTRS));
  assign rd_grant_o  = top_priv || user_rd_en_i;
  assign fault_now_o = (rd_req && !rd_grant_o) ||
                       (req_valid_i && req_write_i && !top_priv);

  for (genvar i = 0; i < NUM_CTRS; i++) begin : g_dec
    logic hit;
    assign hit         = (req_idx_i == IDX_W'(i));
    assign wr_ctr_o[i] = wr_ok && hit && !req_ctl_i;
    assign wr_ctl_o[i] = wr_ok && hit &&  req_ctl_i;
  end

endmodule

// File: rtl/pcb_readout.sv
module pcb_readout import pcb_pkg::*; #(
  parameter int NUM_CTRS = 18,
  parameter int CTR_W    = 40,
  parameter int LOW_W    = 32,
  parameter int IDX_W    = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      rd_req_i,
  input  logic                      rd_grant_i,
  input  logic                      idx_hit_i,
  input  logic                      fault_now_i,
  input  logic                      req_ctl_i,
  input  logic                      req_full_i,
  input  logic [IDX_W-1:0]          req_idx_i,
  input  logic [NUM_CTRS*CTR_W-1:0] cnt_flat_i,
  input  logic [NUM_CTRS-1:0]       en_i,
  input  logic [NUM_CTRS-1:0]       ien_i,
  input  logic [NUM_CTRS-1:0]       ovf_i,
  output logic                      rd_valid_o,
  output logic [REG_W-1:0]          rd_data_o,
  output logic                      fault_o
);

  logic [CTR_W-1:0] cnt_sel;
  logic             en_sel, ien_sel, ovf_sel;
  logic [REG_W-1:0] rd_next;

  always_comb begin
    cnt_sel = '0;
    en_sel  = 1'b0;
    ien_sel = 1'b0;
    ovf_sel = 1'b0;
    if (idx_hit_i) begin
      cnt_sel = cnt_flat_i[int'(req_idx_i)*CTR_W +: CTR_W];
      en_sel  = en_i[req_idx_i];
      ien_sel = ien_i[req_idx_i];
      ovf_sel = ovf_i[req_idx_i];
    end
    rd_next = '0;
    if (rd_grant_i && idx_hit_i) begin
      if (req_ctl_i)
        rd_next = ctl_view(en_sel, ien_sel, ovf_sel);
      else
        rd_next = shape_read({{(REG_W-CTR_W){1'b0}}, cnt_sel},
                             req_full_i, CTR_W, LOW_W);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
      fault_o    <= 1'b0;
    end else begin
      rd_valid_o <= rd_req_i;
      fault_o    <= fault_now_i;
      if (rd_req_i)
        rd_data_o <= rd_next;
    end
  end

endmodule

// File: rtl/perf_counter_bank.sv
module perf_counter_bank import pcb_pkg::*; #(
  parameter int NUM_CTRS = 18,
  parameter int CTR_W    = 40,
  parameter int LOW_W    = 32,
  parameter int PRIV_W   = 2,
  localparam int IDX_W   = $clog2(NUM_CTRS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CTRS-1:0] evt_i,
  input  logic                user_rd_en_i,
  input  logic                req_valid_i,
  input  logic                req_write_i,
  input  logic                req_ctl_i,
  input  logic                req_full_i,
  input  logic [PRIV_W-1:0]   req_priv_i,
  input  logic [IDX_W-1:0]    req_idx_i,
  input  logic [CTR_W-1:0]    req_wdata_i,
  output logic                rd_valid_o,
  output logic [REG_W-1:0]    rd_data_o,
  output logic                fault_o,
  output logic [NUM_CTRS-1:0] irq_o
);

  // named internal events, also watched by the checker
  logic [NUM_CTRS*CTR_W-1:0] cnt_flat;
  logic [NUM_CTRS-1:0]       en_vec, ien_vec, ovf_vec, wrap_vec;
  logic [NUM_CTRS-1:0]       wr_ctr_vec, wr_ctl_vec;
  logic                      rd_grant, idx_hit, fault_now, rd_req;

  assign rd_req = req_valid_i && !req_write_i;

  pcb_access #(
    .NUM_CTRS(NUM_CTRS), .PRIV_W(PRIV_W), .IDX_W(IDX_W)
  ) u_access (
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_ctl_i   (req_ctl_i),
    .req_priv_i  (req_priv_i),
    .req_idx_i   (req_idx_i),
    .user_rd_en_i(user_rd_en_i),
    .wr_ctr_o    (wr_ctr_vec),
    .wr_ctl_o    (wr_ctl_vec),
    .rd_grant_o  (rd_grant),
    .idx_hit_o   (idx_hit),
    .fault_now_o (fault_now)
  );

  for (genvar i = 0; i < NUM_CTRS; i++) begin : g_ctr
    pcb_slice #(.CTR_W(CTR_W)) u_slice (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_i   (evt_i[i]),
      .ld_cnt_i(wr_ctr_vec[i]),
      .ld_ctl_i(wr_ctl_vec[i]),
      .wdata_i (req_wdata_i),
      .cnt_o   (cnt_flat[i*CTR_W +: CTR_W]),
      .en_o    (en_vec[i]),
      .ien_o   (ien_vec[i]),
      .ovf_o   (ovf_vec[i]),
      .irq_o   (irq_o[i]),
      .wrap_o  (wrap_vec[i])
    );
  end

  pcb_readout #(
    .NUM_CTRS(NUM_CTRS), .CTR_W(CTR_W), .LOW_W(LOW_W), .IDX_W(IDX_W)
  ) u_readout (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req_i   (rd_req),
    .rd_grant_i (rd_grant),
    .idx_hit_i  (idx_hit),
    .fault_now_i(fault_now),
    .req_ctl_i  (req_ctl_i),
    .req_full_i (req_full_i),
    .req_idx_i  (req_idx_i),
    .cnt_flat_i (cnt_flat),
    .en_i       (en_vec),
    .ien_i      (ien_vec),
    .ovf_i      (ovf_vec),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o),
    .fault_o    (fault_o)
  );

endmodule

// File: rtl/pcb_checker.sv
module pcb_checker #(
  parameter int NUM_CTRS = 18,
  parameter int CTR_W    = 40,
  parameter int LOW_W    = 32,
  parameter int PRIV_W   = 2,
  parameter int REG_W    = 64
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_CTRS-1:0]       evt_i,
  input logic                      user_rd_en_i,
  input logic                      req_valid_i,
  input logic                      req_write_i,
  input logic                      req_full_i,
  input logic [PRIV_W-1:0]         req_priv_i,
  input logic                      rd_valid_o,
  input logic [REG_W-1:0]          rd_data_o,
  input logic                      fault_o,
  input logic [NUM_CTRS-1:0]       irq_o,
  input logic [NUM_CTRS*CTR_W-1:0] cnt_flat,
  input logic [NUM_CTRS-1:0]       wrap_vec,
  input logic [NUM_CTRS-1:0]       ien_vec
);

  // R1
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> (rd_data_o[REG_W-1:CTR_W] == '0));

  // R2
  narrow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !req_write_i && !req_full_i) |=> (rd_data_o[REG_W-1:LOW_W] == '0));

  // R3
  refused_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !req_write_i && (req_priv_i != '0) && !user_rd_en_i)
      |=> (fault_o && rd_valid_o && (rd_data_o == '0)));

  // R3
  fault_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o |-> $past(req_valid_i));

  // R4
  user_write_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_write_i && (req_priv_i != '0)) |=> fault_o);

  // R4
  user_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_write_i && (req_priv_i != '0) && (evt_i == '0))
      |=> $stable(cnt_flat));

  // R8
  wrap_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|(wrap_vec & ien_vec)) && !(req_valid_i && req_write_i)) |=> (|irq_o));

  // R9
  rd_valid_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> $past(req_valid_i && !req_write_i));

endmodule

bind perf_counter_bank pcb_checker #(
  .NUM_CTRS(NUM_CTRS), .CTR_W(CTR_W), .LOW_W(LOW_W), .PRIV_W(PRIV_W), .REG_W(pcb_pkg::REG_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .evt_i       (evt_i),
  .user_rd_en_i(user_rd_en_i),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_full_i  (req_full_i),
  .req_priv_i  (req_priv_i),
  .rd_valid_o  (rd_valid_o),
  .rd_data_o   (rd_data_o),
  .fault_o     (fault_o),
  .irq_o       (irq_o),
  .cnt_flat    (cnt_flat),
  .wrap_vec    (wrap_vec),
  .ien_vec     (ien_vec)
);

// File: tb/sim_perf_counter_bank.sv
module sim_perf_counter_bank;

  localparam int N  = 18;
  localparam int CW = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  evt_i = '0;
  logic          user_rd_en_i = 1'b0;
  logic          req_valid_i = 1'b0;
  logic          req_write_i = 1'b0;
  logic          req_ctl_i = 1'b0;
  logic          req_full_i = 1'b0;
  logic [1:0]    req_priv_i = '0;
  logic [4:0]    req_idx_i = '0;
  logic [CW-1:0] req_wdata_i = '0;
  logic          rd_valid_o;
  logic [63:0]   rd_data_o;
  logic          fault_o;
  logic [N-1:0]  irq_o;

  int total = 0;
  int bad = 0;
  logic [63:0] got_data;
  logic        got_valid, got_fault;

  always #2 clk = ~clk;

  perf_counter_bank u0 (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic req(input logic wr, input logic ctl, input logic full,
                     input logic [1:0] priv, input int idx, input logic [CW-1:0] wd);
    @(negedge clk);
    req_valid_i = 1'b1; req_write_i = wr; req_ctl_i = ctl; req_full_i = full;
    req_priv_i = priv; req_idx_i = 5'(idx); req_wdata_i = wd;
    @(negedge clk);
    got_data = rd_data_o; got_valid = rd_valid_o; got_fault = fault_o;
    req_valid_i = 1'b0; req_write_i = 1'b0;
  endtask

  task automatic pulse(input int idx, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); evt_i[idx] = 1'b1;
      @(negedge clk); evt_i[idx] = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL R10 watchdog actual=timeout expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [CW-1:0] v, pre;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 rd_valid", 64'(rd_valid_o), 64'd0);
    chk("R10 fault", 64'(fault_o), 64'd0);
    chk("R10 irq", 64'(irq_o), 64'd0);
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) begin
      req(0, 0, 1, 0, i, '0);
      chk("R10 counter zero", got_data, 64'd0);
      req(0, 1, 1, 0, i, '0);
      chk("R10 control zero", got_data, 64'd0);
    end

    // R5 full load, R1 full read, R2 narrow read
    for (int i = 0; i < N; i++) begin
      v = {8'hA0 + 8'(i), 32'hF000_0000 | (32'(i) * 32'h0001_3579)};
      req(1, 0, 0, 0, i, v);
      chk("R4 priv0 write no fault", 64'(got_fault), 64'd0);
      req(0, 0, 1, 0, i, '0);
      chk("R1 R5 full read", got_data, {24'd0, v});
      chk("R9 rd_valid", 64'(got_valid), 64'd1);
      req(0, 0, 0, 0, i, '0);
      chk("R2 narrow read", got_data, {32'd0, v[31:0]});
    end

    // R3 permission sweep on counter 3
    v = {8'hA3, 32'hF000_0000 | (32'd3 * 32'h0001_3579)};
    for (int ue = 0; ue < 2; ue++) begin
      for (int p = 0; p < 4; p++) begin
        logic ok;
        user_rd_en_i = ue[0];
        ok = (p == 0) || (ue == 1);
        req(0, 0, 1, 2'(p), 3, '0);
        chk("R3 read data", got_data, ok ? {24'd0, v} : 64'd0);
        chk("R3 read fault", 64'(got_fault), ok ? 64'd0 : 64'd1);
        chk("R3 R9 refused still valid", 64'(got_valid), 64'd1);
        @(negedge clk);
        chk("R3 fault one cycle", 64'(fault_o), 64'd0);
      end
    end
    user_rd_en_i = 1'b0;

    // R4 unprivileged writes ignored
    for (int p = 1; p < 4; p++) begin
      req(1, 0, 0, 2'(p), 3, 40'h12_3456_789A);
      chk("R4 write fault", 64'(got_fault), 64'd1);
      req(1, 1, 0, 2'(p), 3, 40'h7);
      chk("R4 ctl write fault", 64'(got_fault), 64'd1);
      req(0, 0, 1, 0, 3, '0);
      chk("R4 counter unchanged", got_data, {24'd0, v});
      req(0, 1, 1, 0, 3, '0);
      chk("R4 control unchanged", got_data, 64'd0);
    end

    // R6 disabled counter ignores events
    pulse(0, 3);
    req(0, 0, 1, 0, 0, '0);
    chk("R6 disabled ignores events", got_data, {24'd0, 8'hA0, 32'hF000_0000});

    // R7 preset -N overflows on Nth event; R8 irq; R6 W1C
    for (int i = 0; i < N; i++) begin
      pre = CW'(0) - CW'(i + 1);
      req(1, 0, 0, 0, i, pre);
      req(1, 1, 0, 0, i, 40'h3);
      pulse(i, i);
      req(0, 0, 1, 0, i, '0);
      chk("R6 R7 count reaches all-ones", got_data, {24'd0, {CW{1'b1}}});
      req(0, 1, 1, 0, i, '0);
      chk("R7 no overflow before Nth", got_data, 64'h3);
      chk("R8 irq low before wrap", 64'(irq_o[i]), 64'd0);
      pulse(i, 1);
      chk("R8 irq after wrap", 64'(irq_o[i]), 64'd1);
      req(0, 1, 1, 0, i, '0);
      chk("R7 overflow flag set", got_data, 64'h7);
      req(0, 0, 1, 0, i, '0);
      chk("R7 wrapped to zero", got_data, 64'd0);
      req(1, 1, 0, 0, i, 40'h1);
      chk("R8 irq masked", 64'(irq_o[i]), 64'd0);
      req(0, 1, 1, 0, i, '0);
      chk("R7 flag sticky", got_data, 64'h5);
      req(1, 1, 0, 0, i, 40'h3);
      chk("R8 irq back", 64'(irq_o[i]), 64'd1);
      req(1, 1, 0, 0, i, 40'h7);
      chk("R6 W1C clears irq", 64'(irq_o), 64'd0);
      req(0, 1, 1, 0, i, '0);
      chk("R6 W1C clears flag", got_data, 64'h3);
    end

    // R6 enabled counter counts each event
    req(1, 0, 0, 0, 7, 40'd100);
    pulse(7, 5);
    req(0, 0, 1, 0, 7, '0);
    chk("R6 counts events", got_data, 64'd105);

    // R5 write beats same-cycle event
    @(negedge clk);
    evt_i[5] = 1'b1;
    req_valid_i = 1'b1; req_write_i = 1'b1; req_ctl_i = 1'b0;
    req_priv_i = 2'd0; req_idx_i = 5'd5; req_wdata_i = 40'h12345;
    @(negedge clk);
    evt_i[5] = 1'b0; req_valid_i = 1'b0; req_write_i = 1'b0;
    req(0, 0, 1, 0, 5, '0);
    chk("R5 write wins over event", got_data, 64'h12345);

    // R9 out-of-range index
    for (int idx = N; idx < 32; idx += 6) begin
      req(0, 0, 1, 0, idx, '0);
      chk("R9 out-of-range read zero", got_data, 64'd0);
      chk("R9 out-of-range no fault", 64'(got_fault), 64'd0);
      req(1, 0, 1, 0, idx, 40'hFF);
      chk("R9 out-of-range write no fault", 64'(got_fault), 64'd0);
    end
    req(0, 0, 1, 0, 5, '0);
    chk("R9 neighbours untouched", got_data, 64'h12345);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule